// File: doc/BRIEF.md
# Indexed Display Controller Register Bank

This block holds the configuration registers of a display controller: a timing group of 25 registers, a sequencer group of 5 and a graphics group of 9. Software reaches each group through two I/O ports. A byte written to the index port selects a register, and the next byte written to the data port stores into it. A 16-bit write to the index port does both in one bus cycle. The low byte is the index and the high byte is the value.

Timing register 0x11 carries a protect bit (bit 7). While that bit is set, timing registers 0x00 to 0x07 cannot be changed. Register 0x11 itself stays writable, so software can always clear the protection. The vertical total, display end, sync start and blank start values are split. Their low bytes are in registers 0x06, 0x12, 0x10 and 0x15, and their high bits are spread across the overflow register 0x07. The block puts them back together on dedicated outputs that feed the raster generator.

The bus is a plain synchronous register port. A read returns its byte one cycle after the request, with a valid strobe.

Top module: `disp_regbank`

## Requirements
- R1: Byte writes to the index port store the index, and a read of that port returns it unchanged. The index ports are 0x3D4 (timing), 0x3C4 (sequencer) and 0x3CE (graphics). Each data port is at its index port address plus one.
- R2: A read of a data port returns the register selected by that group's stored index. rdata_o carries the byte, with rvalid_o high, in the cycle after rd_i is sampled.
- R3: A write with wide_i=1 to an index port stores wdata_i[7:0] as the index and writes wdata_i[15:8] into that register. A write with wide_i=1 to a data port is dropped.
- R4: The groups hold 25, 5 and 9 registers. For an index at or beyond the group count, a data read returns 0 and a data write changes no register.
- R5: While bit 7 of timing register 0x11 is 1, writes to timing registers 0x00 to 0x07 are ignored. Timing registers 0x08 and above still accept writes. Clearing the bit makes registers 0x00 to 0x07 writable again.
- R6: Timing register 0x11 accepts every write, including while its bit 7 is set.
- R7: vtotal_o = {reg07[5], reg07[0], reg06}.
- R8: vdisp_end_o = {reg07[6], reg07[1], reg12}.
- R9: vsync_start_o = {reg07[7], reg07[2], reg10}.
- R10: vblank_start_o = {reg07[3], reg15}. This output is 9 bits wide.
- R11: Reset (rst_ni low) clears every register and every index to 0, which also clears the protect bit.
- R12: A read of an address outside the six ports returns 0, and a write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | I/O port address |
| wr_i | input | 1 | Write strobe |
| wide_i | input | 1 | Write is 16-bit (index in low byte, value in high byte) |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 8 | Read data, one cycle after rd_i |
| rvalid_o | output | 1 | rdata_o is valid |
| vtotal_o | output | 10 | Rebuilt vertical total |
| vdisp_end_o | output | 10 | Rebuilt vertical display end |
| vsync_start_o | output | 10 | Rebuilt vertical sync start |
| vblank_start_o | output | 9 | Rebuilt vertical blank start |

## Verification
The bench drives the overflow register with patterns that set bit 8 and bit 9 of each vertical value on their own. A design that crossed two overflow bits, or placed a bit one position off, would show a wrong value on one of the vertical outputs.

Under protection, the bench tries to change overflow register 0x07 and register 0x00, and expects both to keep their values. It also writes register 0x11 while protected, because a design that protected 0x11 could never be unlocked. It then writes register 0x08, which a design with too wide a protect range would refuse.

Out-of-range sequencer indices are written and then every in-range register is read back. A design that dropped the upper index bits would overwrite a low register. A 16-bit write sent to a data port must leave the selected register unchanged.

// File: rtl/disp_regbank_pkg.sv
package disp_regbank_pkg;
  localparam int DAT_W = 8;
  typedef logic [DAT_W-1:0] byte_t;

  typedef enum int {GRP_TIM = 0, GRP_SEQ = 1, GRP_GFX = 2} grp_e;
  localparam int NUM_GRP = 3;

  // timing register indices used by the vertical decode
  localparam int REG_VTOT = 8'h06;
  localparam int REG_OVF  = 8'h07;
  localparam int REG_VSS  = 8'h10;
  localparam int REG_VDE  = 8'h12;
  localparam int REG_VBS  = 8'h15;

  // overflow register bit positions
  localparam int OVF_VT8 = 0;
  localparam int OVF_DE8 = 1;
  localparam int OVF_VS8 = 2;
  localparam int OVF_VB8 = 3;
  localparam int OVF_VT9 = 5;
  localparam int OVF_DE9 = 6;
  localparam int OVF_VS9 = 7;
endpackage

// File: rtl/dreg_group.sv
module dreg_group
  import disp_regbank_pkg::*;
#(
  parameter int NREGS     = 5,
  parameter bit LOCK_EN   = 1'b0,
  parameter int LOCK_REG  = 0,
  parameter int LOCK_BIT  = 7,
  parameter int LOCK_SPAN = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               idx_we_i,
  input  byte_t              idx_wdata_i,
  input  logic               dat_we_i,
  input  byte_t              dat_wdata_i,
  output byte_t              idx_o,
  output byte_t              dat_o,
  output logic [NREGS*8-1:0] regs_o
);
  byte_t idx_q;
  byte_t regs_q [NREGS];
  byte_t eff_idx;
  logic  lock_active;
  logic  wr_blocked;

  // 16-bit writes load the index and use it in the same cycle
  assign eff_idx = idx_we_i ? idx_wdata_i : idx_q;

  if (LOCK_EN) begin : g_lock
    assign lock_active = regs_q[LOCK_REG][LOCK_BIT];
  end else begin : g_nolock
    assign lock_active = 1'b0;
  end

  assign wr_blocked = lock_active && (int'(eff_idx) < LOCK_SPAN)
                      && (int'(eff_idx) != LOCK_REG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (idx_we_i) idx_q <= idx_wdata_i;
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[i] <= '0;
      else if (dat_we_i && (eff_idx == DAT_W'(i)) && !wr_blocked)
        regs_q[i] <= dat_wdata_i;
    end
    assign regs_o[i*8 +: 8] = regs_q[i];
  end

  always_comb begin
    dat_o = '0;
    for (int i = 0; i < NREGS; i++)
      if (idx_q == DAT_W'(i)) dat_o = regs_q[i];
  end

  assign idx_o = idx_q;

  AST_IDX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_we_i |=> idx_o == $past(idx_wdata_i)); // R1

  if (LOCK_EN) begin : g_lock_chk
    for (genvar i = 0; i < LOCK_SPAN; i++) begin : g_hold
      if (i != LOCK_REG && i < NREGS) begin : g_one
        AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (lock_active && dat_we_i && eff_idx == DAT_W'(i)) |=> $stable(regs_q[i])); // R5
      end
    end
    AST_LOCKREG_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dat_we_i && eff_idx == DAT_W'(LOCK_REG))
        |=> regs_q[LOCK_REG] == $past(dat_wdata_i)); // R6
  end
endmodule

// File: rtl/vtiming_decode.sv
module vtiming_decode
  import disp_regbank_pkg::*;
(
  input  byte_t       vtot_lo_i,
  input  byte_t       vde_lo_i,
  input  byte_t       vss_lo_i,
  input  byte_t       vbs_lo_i,
  input  byte_t       ovf_i,
  output logic [9:0]  vtotal_o,
  output logic [9:0]  vdisp_end_o,
  output logic [9:0]  vsync_start_o,
  output logic [8:0]  vblank_start_o
);
  logic ovf_unused;
  assign ovf_unused = ovf_i[4];

  assign vtotal_o       = {ovf_i[OVF_VT9], ovf_i[OVF_VT8], vtot_lo_i};
  assign vdisp_end_o    = {ovf_i[OVF_DE9], ovf_i[OVF_DE8], vde_lo_i};
  assign vsync_start_o  = {ovf_i[OVF_VS9], ovf_i[OVF_VS8], vss_lo_i};
  assign vblank_start_o = {ovf_i[OVF_VB8], vbs_lo_i};
endmodule

// File: rtl/disp_regbank.sv
module disp_regbank
  import disp_regbank_pkg::*;
#(
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] TIM_IDX_PORT = 16'h03D4,
  parameter logic [ADDR_W-1:0] SEQ_IDX_PORT = 16'h03C4,
  parameter logic [ADDR_W-1:0] GFX_IDX_PORT = 16'h03CE,
  parameter int                TIM_NREGS    = 25,
  parameter int                SEQ_NREGS    = 5,
  parameter int                GFX_NREGS    = 9,
  parameter int                LOCK_REG     = 8'h11,
  parameter int                LOCK_BIT     = 7,
  parameter int                LOCK_SPAN    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic              rd_i,
  input  logic [15:0]       wdata_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output logic [9:0]        vtotal_o,
  output logic [9:0]        vdisp_end_o,
  output logic [9:0]        vsync_start_o,
  output logic [8:0]        vblank_start_o
);
  localparam logic [ADDR_W-1:0] IDX_PORT [NUM_GRP] = '{TIM_IDX_PORT, SEQ_IDX_PORT, GFX_IDX_PORT};

  logic  [NUM_GRP-1:0] idx_hit, dat_hit, idx_we, dat_we;
  byte_t               grp_idx [NUM_GRP];
  byte_t               grp_dat [NUM_GRP];
  byte_t               dat_wdata;
  byte_t               rd_mux;
  logic                mapped;
  byte_t               rdata_q;
  logic                rvalid_q;

  logic [TIM_NREGS*8-1:0] tim_regs;
  logic [SEQ_NREGS*8-1:0] seq_regs_unused;
  logic [GFX_NREGS*8-1:0] gfx_regs_unused;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
    assign idx_hit[g] = (addr_i == IDX_PORT[g]);
    assign dat_hit[g] = (addr_i == IDX_PORT[g] + ADDR_W'(1));
    assign idx_we[g]  = wr_i && idx_hit[g];
    assign dat_we[g]  = wr_i && ((dat_hit[g] && !wide_i) || (idx_hit[g] && wide_i));
  end

  assign dat_wdata = wide_i ? wdata_i[15:8] : wdata_i[7:0];
  assign mapped    = |{idx_hit, dat_hit};

  dreg_group #(.NREGS(TIM_NREGS), .LOCK_EN(1'b1), .LOCK_REG(LOCK_REG),
               .LOCK_BIT(LOCK_BIT), .LOCK_SPAN(LOCK_SPAN)) u_tim (
    .clk_i, .rst_ni,
    .idx_we_i(idx_we[GRP_TIM]), .idx_wdata_i(wdata_i[7:0]),
    .dat_we_i(dat_we[GRP_TIM]), .dat_wdata_i(dat_wdata),
    .idx_o(grp_idx[GRP_TIM]), .dat_o(grp_dat[GRP_TIM]), .regs_o(tim_regs));

  dreg_group #(.NREGS(SEQ_NREGS), .LOCK_EN(1'b0), .LOCK_REG(0),
               .LOCK_BIT(LOCK_BIT), .LOCK_SPAN(LOCK_SPAN)) u_seq (
    .clk_i, .rst_ni,
    .idx_we_i(idx_we[GRP_SEQ]), .idx_wdata_i(wdata_i[7:0]),
    .dat_we_i(dat_we[GRP_SEQ]), .dat_wdata_i(dat_wdata),
    .idx_o(grp_idx[GRP_SEQ]), .dat_o(grp_dat[GRP_SEQ]), .regs_o(seq_regs_unused));

  dreg_group #(.NREGS(GFX_NREGS), .LOCK_EN(1'b0), .LOCK_REG(0),
               .LOCK_BIT(LOCK_BIT), .LOCK_SPAN(LOCK_SPAN)) u_gfx (
    .clk_i, .rst_ni,
    .idx_we_i(idx_we[GRP_GFX]), .idx_wdata_i(wdata_i[7:0]),
    .dat_we_i(dat_we[GRP_GFX]), .dat_wdata_i(dat_wdata),
    .idx_o(grp_idx[GRP_GFX]), .dat_o(grp_dat[GRP_GFX]), .regs_o(gfx_regs_unused));

  vtiming_decode u_vdec (
    .vtot_lo_i(tim_regs[REG_VTOT*8 +: 8]),
    .vde_lo_i (tim_regs[REG_VDE*8 +: 8]),
    .vss_lo_i (tim_regs[REG_VSS*8 +: 8]),
    .vbs_lo_i (tim_regs[REG_VBS*8 +: 8]),
    .ovf_i    (tim_regs[REG_OVF*8 +: 8]),
    .vtotal_o, .vdisp_end_o, .vsync_start_o, .vblank_start_o);

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (idx_hit[g]) rd_mux = grp_idx[g];
      if (dat_hit[g]) rd_mux = grp_dat[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o); // R2
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !mapped) |=> rdata_o == 8'h00); // R12
  AST_VT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(vtotal_o) && $stable(vdisp_end_o)); // R7
  AST_VS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(vsync_start_o) && $stable(vblank_start_o)); // R9
endmodule

// File: tb/disp_regbank_bench.sv
module disp_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, wide = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic [9:0]  vtot, vde, vss;
  logic [8:0]  vbs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  disp_regbank u_disp_regbank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wide_i(wide),
    .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .vtotal_o(vtot), .vdisp_end_o(vde), .vsync_start_o(vss), .vblank_start_o(vbs));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr8(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr = 1'b1; wide = 1'b0; wdata = {8'h00, d};
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wr16(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wr = 1'b1; wide = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; wide = 1'b0;
  endtask

  task automatic rd8(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected rvalid actual=%0h expected=none", rdata);
      end else begin
        chk(32'(rdata), 32'(exp_q.pop_front()), tag_q.pop_front());
      end
    end
  end

  task automatic vchk(input logic [9:0] t, input logic [9:0] de, input logic [9:0] s,
                      input logic [8:0] b, input string tag);
    chk(32'(vtot), 32'(t),  {tag, " R7 vtotal"});
    chk(32'(vde),  32'(de), {tag, " R8 vdisp_end"});
    chk(32'(vss),  32'(s),  {tag, " R9 vsync_start"});
    chk(32'(vbs),  32'(b),  {tag, " R10 vblank_start"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    rd8(16'h03D4, 8'h00, "R11 timing index after reset");
    rd8(16'h03D5, 8'h00, "R11 timing reg0 after reset");
    vchk(10'h000, 10'h000, 10'h000, 9'h000, "R11 reset");

    // R1 / R2 byte access
    wr8(16'h03D4, 8'h06);
    wr8(16'h03D5, 8'hBF);
    rd8(16'h03D4, 8'h06, "R1 timing index readback");
    rd8(16'h03D5, 8'hBF, "R2 timing reg06 data");

    // R3 wide write
    wr16(16'h03D4, 16'h5510);
    rd8(16'h03D4, 8'h10, "R3 wide write index");
    rd8(16'h03D5, 8'h55, "R3 wide write data");
    wr8(16'h03D4, 8'h12);
    wr8(16'h03D5, 8'h8F);
    wr16(16'h03D4, 16'h9615);

    // R7-R10 overflow patterns
    wr16(16'h03D4, 16'hEF07);
    vchk(10'h3BF, 10'h38F, 10'h355, 9'h196, "ovf=EF");
    wr16(16'h03D4, 16'h2007);
    vchk(10'h2BF, 10'h08F, 10'h055, 9'h096, "ovf=20");
    wr16(16'h03D4, 16'h8207);
    vchk(10'h0BF, 10'h18F, 10'h255, 9'h096, "ovf=82");
    wr16(16'h03D4, 16'h0807);
    vchk(10'h0BF, 10'h08F, 10'h055, 9'h196, "ovf=08");
    wr16(16'h03D4, 16'h8207);

    // other groups
    wr16(16'h03C4, 16'hA403);
    rd8(16'h03C5, 8'hA4, "R2 sequencer reg3");
    wr16(16'h03CE, 16'h3C08);
    rd8(16'h03CF, 8'h3C, "R2 graphics reg8");
    rd8(16'h03CE, 8'h08, "R1 graphics index");

    // R4 out-of-range indices
    wr8(16'h03C4, 8'h05);
    rd8(16'h03C4, 8'h05, "R1 sequencer index beyond count");
    rd8(16'h03C5, 8'h00, "R4 sequencer idx5 reads zero");
    wr8(16'h03C5, 8'h77);
    wr16(16'h03C4, 16'h6607);
    rd8(16'h03C5, 8'h00, "R4 sequencer idx7 reads zero");
    for (int i = 0; i < 5; i++) begin
      wr8(16'h03C4, 8'(i));
      rd8(16'h03C5, (i == 3) ? 8'hA4 : 8'h00, "R4 sequencer in-range unchanged");
    end
    wr16(16'h03CE, 16'h4409);
    rd8(16'h03CF, 8'h00, "R4 graphics idx9 reads zero");
    wr16(16'h03D4, 16'h1119);
    rd8(16'h03D5, 8'h00, "R4 timing idx19 reads zero");

    // R5 / R6 protect bit
    wr16(16'h03D4, 16'h5F00);
    wr16(16'h03D4, 16'h8E11);
    rd8(16'h03D5, 8'h8E, "R6 lock reg written");
    wr16(16'h03D4, 16'h1100);
    rd8(16'h03D5, 8'h5F, "R5 locked reg0 unchanged");
    wr16(16'h03D4, 16'h0107);
    vchk(10'h0BF, 10'h18F, 10'h255, 9'h096, "R5 locked overflow");
    wr16(16'h03D4, 16'h3308);
    rd8(16'h03D5, 8'h33, "R5 reg08 writable under lock");
    wr16(16'h03D4, 16'h8511);
    rd8(16'h03D5, 8'h85, "R6 lock reg writable while locked");
    wr16(16'h03D4, 16'h0E11);
    rd8(16'h03D5, 8'h0E, "R6 lock cleared");
    wr16(16'h03D4, 16'h2200);
    rd8(16'h03D5, 8'h22, "R5 reg0 writable after unlock");

    // R3 wide write to data port dropped
    wr16(16'h03D5, 16'h9900);
    rd8(16'h03D5, 8'h22, "R3 wide write to data port dropped");
    rd8(16'h03D4, 8'h00, "R3 index kept after dropped wide write");

    // R12 unmapped
    wr8(16'h03C0, 8'hFF);
    rd8(16'h03C0, 8'h00, "R12 unmapped read");
    rd8(16'h03D0, 8'h00, "R12 unmapped read 2");
    rd8(16'h03D5, 8'h22, "R12 unmapped write left reg0");

    // R11 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    vchk(10'h000, 10'h000, 10'h000, 9'h000, "R11 second reset");
    rd8(16'h03C4, 8'h00, "R11 sequencer index cleared");
    wr8(16'h03D4, 8'h08);
    rd8(16'h03D5, 8'h00, "R11 timing reg08 cleared");
    wr16(16'h03D4, 16'h4400);
    rd8(16'h03D5, 8'h44, "R11 lock cleared by reset");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule